// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one column access request into the ordered list of column addresses that an SDRAM burst visits. A controller pulses `start` together with the first column, the burst-length code, the ordering type and the access direction. From the next clock on, the block presents one column per cycle with `valid`, and it marks the final beat with `last`.

Finite bursts of 2, 4 or 8 beats wrap inside the naturally aligned block that holds the first column. The columns inside the block are visited either in incrementing order or in XOR (interleaved) order. Page mode walks all 256 columns of the row in a cycle and keeps going until a stop request ends it. A stop request cuts any burst short. When single-location writes are selected, every write becomes a one-beat access.

The core is a three-state machine. `ST_IDLE` presents nothing. `ST_BURST` counts a finite burst. `ST_PAGE` runs an open-ended page walk. The transitions are:
- launch: any state goes to `ST_BURST` or `ST_PAGE` on `start`. It stays in or returns to `ST_IDLE` when the burst is one beat long.
- finish: `ST_BURST` goes to `ST_IDLE` when the final beat is issued.
- cut: `ST_BURST` or `ST_PAGE` goes to `ST_IDLE` on `stop`.
- hold: every other case keeps the current state.

Top module: `sdr_burst_colgen`

## Requirements
- R1: After reset, and until the first `start`, `valid`, `last` and `cfg_err` are all low.
- R2: On the clock edge after `start` is sampled high, `valid` is high and `col` equals the sampled `start_col`.
- R3: `bl_code` selects the burst length as 000 = 1, 001 = 2, 010 = 4 and 011 = 8 beats. `last` is high only on the final beat, and `valid` drops on the cycle after it unless a new `start` arrives.
- R4: With `burst_type` = 0 (sequential), beat k presents the low log2(length) bits as (start + k) modulo the length. The upper bits equal those of `start_col`. For example, length 8 from 0x25 gives 25,26,27,20,21,22,23,24.
- R5: With `burst_type` = 1 (interleaved), beat k presents `start_col` XOR k for k below the length. For example, length 8 from 0x25 gives 25,24,27,26,21,20,23,22.
- R6: `bl_code` = 111 with sequential type is page mode. Columns increment by one modulo 256 each beat, wrapping from 0xFF to 0x00. `last` stays low until a stop is accepted.
- R7: `stop` sampled high while a burst has beats left makes the beat issued at that same edge the final one, with `last` high. `stop` has no effect while no burst is running.
- R8: When `is_write` and `wb_single` are both high at `start`, the access is one beat long whatever `bl_code` says. A read with `wb_single` high keeps the programmed length.
- R9: The codes 100, 101 and 110, and code 111 with interleaved type, give a one-beat access and raise `cfg_err` on its beat. `cfg_err` holds until the next `start`, which reloads it.
- R10: A `start` sampled during a running burst abandons that burst. The next beat is the first beat of the new burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a burst with the inputs below |
| start_col | input | 8 | First column of the burst |
| bl_code | input | 3 | Burst length code |
| burst_type | input | 1 | 0 sequential, 1 interleaved |
| is_write | input | 1 | Access is a write |
| wb_single | input | 1 | Writes are single-location accesses |
| stop | input | 1 | End the running burst |
| col | output | 8 | Column of the current beat |
| valid | output | 1 | A beat is presented |
| last | output | 1 | Current beat is the final one |
| cfg_err | output | 1 | Launching configuration was reserved |

## Verification
The properties assume that `start`, `stop` and the configuration inputs are stable across each rising edge. They also assume that the configuration inputs matter only in the cycle where `start` is high. The stop property expects `start` low in the same cycle, because a simultaneous launch takes priority. The stimulus changes every input only on falling edges. It holds `start` for exactly one cycle per launch, and it returns `stop` low after one cycle. It raises `start` mid-burst only in the dedicated restart scenario.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } burst_st_e;

    localparam logic [2:0] BLC_ONE   = 3'b000;
    localparam logic [2:0] BLC_TWO   = 3'b001;
    localparam logic [2:0] BLC_FOUR  = 3'b010;
    localparam logic [2:0] BLC_EIGHT = 3'b011;
    localparam logic [2:0] BLC_PAGE  = 3'b111;

endpackage

// File: rtl/sdr_bl_decode.sv
module sdr_bl_decode
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       code,
    input  logic             ilv,
    input  logic             is_write,
    input  logic             wb_single,
    output logic [COL_W-1:0] span_mask,
    output logic             page,
    output logic             cfg_err
);
    logic [COL_W-1:0] raw_mask;
    logic             raw_page;

    // Length code to a low-ones mask; reserved codes collapse to one beat.
    always_comb begin
        raw_mask = '0;
        raw_page = 1'b0;
        cfg_err  = 1'b0;
        case (code)
            BLC_ONE:   raw_mask = COL_W'(0);
            BLC_TWO:   raw_mask = COL_W'(1);
            BLC_FOUR:  raw_mask = COL_W'(3);
            BLC_EIGHT: raw_mask = COL_W'(7);
            BLC_PAGE: begin
                if (ilv) cfg_err = 1'b1;
                else begin
                    raw_mask = '1;
                    raw_page = 1'b1;
                end
            end
            default:   cfg_err = 1'b1;
        endcase
    end

    // Single-location write mode overrides the programmed length.
    always_comb begin
        if (is_write && wb_single) begin
            span_mask = '0;
            page      = 1'b0;
        end else begin
            span_mask = raw_mask;
            page      = raw_page;
        end
    end

endmodule

// File: rtl/sdr_col_step.sv
module sdr_col_step #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum;

    assign sum = base + idx;

    // Bits inside the mask walk; bits above it keep the start value.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!mask[b])  col[b] = base[b];
            else if (ilv)  col[b] = base[b] ^ idx[b];
            else           col[b] = sum[b];
        end
    end

endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int BLC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [BLC_W-1:0] bl_code,
    input  logic             burst_type,
    input  logic             is_write,
    input  logic             wb_single,
    input  logic             stop,
    output logic [COL_W-1:0] col,
    output logic             valid,
    output logic             last,
    output logic             cfg_err
);
    localparam logic [COL_W-1:0] ONE_IDX = COL_W'(1);

    burst_st_e        st_q, st_nx;
    logic [COL_W-1:0] base_q, mask_q, idx_q;
    logic             ilv_q;
    logic [COL_W-1:0] dec_mask, cur_col;
    logic             dec_page, dec_err, dec_single, at_end;

    sdr_bl_decode #(.COL_W(COL_W)) u_dec (
        .code      (bl_code),
        .ilv       (burst_type),
        .is_write  (is_write),
        .wb_single (wb_single),
        .span_mask (dec_mask),
        .page      (dec_page),
        .cfg_err   (dec_err)
    );

    sdr_col_step #(.COL_W(COL_W)) u_step (
        .base (base_q),
        .idx  (idx_q),
        .mask (mask_q),
        .ilv  (ilv_q),
        .col  (cur_col)
    );

    assign dec_single = (dec_mask == '0) && !dec_page;
    assign at_end     = (idx_q == mask_q);

    // Next-state logic.
    always_comb begin
        st_nx = st_q;
        if (start) begin
            if (dec_single)    st_nx = ST_IDLE;
            else if (dec_page) st_nx = ST_PAGE;
            else               st_nx = ST_BURST;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_nx = ST_IDLE;
                ST_BURST: st_nx = (at_end || stop) ? ST_IDLE : ST_BURST;
                ST_PAGE:  st_nx = stop ? ST_IDLE : ST_PAGE;
                default:  st_nx = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // Output and burst-context registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            mask_q  <= '0;
            idx_q   <= '0;
            ilv_q   <= 1'b0;
            col     <= '0;
            valid   <= 1'b0;
            last    <= 1'b0;
            cfg_err <= 1'b0;
        end else if (start) begin
            base_q  <= start_col;
            mask_q  <= dec_mask;
            ilv_q   <= burst_type && !dec_page;
            idx_q   <= ONE_IDX;
            col     <= start_col;
            valid   <= 1'b1;
            last    <= dec_single;
            cfg_err <= dec_err;
        end else begin
            unique case (st_q)
                ST_BURST: begin
                    col   <= cur_col;
                    valid <= 1'b1;
                    last  <= at_end || stop;
                    idx_q <= idx_q + ONE_IDX;
                end
                ST_PAGE: begin
                    col   <= cur_col;
                    valid <= 1'b1;
                    last  <= stop;
                    idx_q <= idx_q + ONE_IDX;
                end
                default: begin
                    valid <= 1'b0;
                    last  <= 1'b0;
                end
            endcase
        end
    end

    // R2: the first beat shows the sampled start column
    p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid && (col == $past(start_col)));

    // R3: nothing follows a final beat unless a new burst is launched
    p_quiet_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> !valid);

    // R4: bits above the burst block never move within a burst
    p_upper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !last && !start) |=> (((col ^ $past(col)) & ~mask_q) == '0));

    // R7: an accepted stop makes the next beat the final one
    p_stop_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !last && stop && !start) |=> (valid && last));

    // R8: single-location writes take one beat
    p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && is_write && wb_single) |=> (valid && last));

    // R9: reserved configurations flag an error on a one-beat access
    p_reserved_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ((bl_code[2] && (bl_code[1:0] != 2'b11)) ||
                   (bl_code == 3'b111 && burst_type)))
        |=> (cfg_err && last));

endmodule

// File: tb/sdr_burst_colgen_bench.sv
module sdr_burst_colgen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] bl_code = '0;
    logic       burst_type = 1'b0;
    logic       is_write = 1'b0;
    logic       wb_single = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] col;
    logic       valid, last, cfg_err;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    sdr_burst_colgen u_sdr_burst_colgen (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .bl_code(bl_code), .burst_type(burst_type), .is_write(is_write),
        .wb_single(wb_single), .stop(stop), .col(col), .valid(valid),
        .last(last), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic int exp_col(input int s, input int k, input int len,
                                   input bit ilv, input bit page);
        if (page) return (s + k) % 256;
        if (ilv)  return s ^ k;
        return (s & ~(len - 1)) | ((s + k) & (len - 1));
    endfunction

    // Launch one burst and check every beat; stop_at = beat on which stop is raised.
    task automatic run_burst(input string tag, input logic [2:0] code, input bit ilv,
                             input bit wr, input bit wbs, input logic [7:0] s,
                             input int len, input bit page, input int nbeats,
                             input int stop_at, input bit exp_err);
        @(negedge clk);
        start = 1'b1; start_col = s; bl_code = code; burst_type = ilv;
        is_write = wr; wb_single = wbs;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < nbeats; k++) begin
            chk({tag, " valid"}, int'(valid), 1);
            chk({tag, " col"}, int'(col), exp_col(int'(s), k, len, ilv, page));
            chk({tag, " last"}, int'(last), (k == nbeats - 1) ? 1 : 0);
            if (k == 0) chk({tag, " cfg_err"}, int'(cfg_err), int'(exp_err));
            stop = (k == stop_at);
            @(negedge clk);
            stop = 1'b0;
        end
        chk({tag, " valid after end"}, int'(valid), 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", int'(valid), 0);
        chk("R1 last", int'(last), 0);
        chk("R1 cfg_err", int'(cfg_err), 0);
    endtask

    task automatic t_lengths;
        run_burst("R3 R2 len1", 3'b000, 0, 0, 0, 8'h37, 1, 0, 1, -1, 0);
        run_burst("R3 len2", 3'b001, 0, 0, 0, 8'h37, 2, 0, 2, -1, 0);
        run_burst("R3 R4 len4", 3'b010, 0, 0, 0, 8'h36, 4, 0, 4, -1, 0);
        run_burst("R4 len8 seq", 3'b011, 0, 0, 0, 8'h25, 8, 0, 8, -1, 0);
    endtask

    task automatic t_interleave;
        run_burst("R5 len8 ilv", 3'b011, 1, 0, 0, 8'h25, 8, 0, 8, -1, 0);
        run_burst("R5 len4 ilv", 3'b010, 1, 0, 0, 8'hC2, 4, 0, 4, -1, 0);
        run_burst("R5 len2 ilv", 3'b001, 1, 0, 0, 8'h91, 2, 0, 2, -1, 0);
    endtask

    task automatic t_page;
        run_burst("R6 page wrap", 3'b111, 0, 0, 0, 8'hFE, 256, 1, 7, 5, 0);
        run_burst("R6 page long", 3'b111, 0, 0, 0, 8'h10, 256, 1, 260, 258, 0);
    endtask

    task automatic t_stop;
        run_burst("R7 stop len8", 3'b011, 0, 0, 0, 8'h44, 8, 0, 4, 2, 0);
        run_burst("R7 stop ilv", 3'b011, 1, 0, 0, 8'h45, 8, 0, 2, 0, 0);
        stop = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R7 idle stop valid", int'(valid), 0);
            chk("R7 idle stop last", int'(last), 0);
        end
        stop = 1'b0;
    endtask

    task automatic t_single_write;
        run_burst("R8 write single", 3'b011, 0, 1, 1, 8'h5A, 1, 0, 1, -1, 0);
        run_burst("R8 read keeps len", 3'b011, 0, 0, 1, 8'h5A, 8, 0, 8, -1, 0);
        run_burst("R8 write burst", 3'b010, 1, 1, 0, 8'h5A, 4, 0, 4, -1, 0);
        run_burst("R8 write page single", 3'b111, 0, 1, 1, 8'h77, 1, 0, 1, -1, 0);
    endtask

    task automatic t_reserved;
        for (int c = 4; c < 7; c++)
            run_burst("R9 reserved code", 3'(c), 0, 0, 0, 8'h63, 1, 0, 1, -1, 1);
        run_burst("R9 page ilv", 3'b111, 1, 0, 0, 8'h63, 1, 0, 1, -1, 1);
        repeat (2) @(negedge clk);
        chk("R9 err held", int'(cfg_err), 1);
        run_burst("R9 err cleared", 3'b001, 0, 0, 0, 8'h63, 2, 0, 2, -1, 0);
    endtask

    task automatic t_restart;
        @(negedge clk);
        start = 1'b1; start_col = 8'h10; bl_code = 3'b011; burst_type = 1'b0;
        is_write = 1'b0; wb_single = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk("R10 old beat0", int'(col), 8'h10);
        @(negedge clk);
        chk("R10 old beat1", int'(col), 8'h11);
        start = 1'b1; start_col = 8'h81; bl_code = 3'b010; burst_type = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R10 new valid", int'(valid), 1);
            chk("R10 new col", int'(col), 8'h81 ^ k);
            chk("R10 new last", int'(last), (k == 3) ? 1 : 0);
            @(negedge clk);
        end
        chk("R10 end", int'(valid), 0);
    endtask

    initial begin
        t_reset();
        t_lengths();
        t_interleave();
        t_page();
        t_stop();
        t_single_write();
        t_reserved();
        t_restart();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule